// File: doc/BRIEF.md
# SRAM Access Timing Sequencer

This block is a synchronous controller that issues the ordered control pulses that a precharged static RAM macro needs for each access. A single request carries a read/write flag and a row address. Once the request is taken, the block runs a fixed sequence of phases: bit-line precharge, a one-cycle address-latch phase, word-line enable, then either sense-amplifier enable (read) or write-driver enable alongside the word line (write), and finally a recovery interval.

The sequence keeps unsafe overlaps from happening. Precharge is always fully off for at least one cycle before the word line rises. The row address presented to the array is frozen from the latch phase until the access completes. No word line is driven during recovery. Writes get a longer recovery than reads, so the bit lines can settle back to their resting level. Every phase length is a parameter. A new request is only considered while the block is idle.

Top module: `sram_seq_top`

## Requirements
- R1: While reset is held, and in the first cycle after it, every control output and `busy_o` are low.
- R2: A request seen at a clock edge while idle is accepted. `busy_o` is then high for exactly PRE_CYC+1+WORD_CYC+SENSE_CYC+RREC_CYC cycles for a read, or PRE_CYC+1+WORD_CYC+WREC_CYC cycles for a write. With the request held high, consecutive accesses start one idle cycle apart.
- R3: `precharge_o` is high for PRE_CYC cycles, starting in the cycle after acceptance.
- R4: `word_en_o` is never high together with `precharge_o`. Between the two there is exactly one cycle in which `addr_le_o` is high and both are low.
- R5: `row_addr_o` takes the requested address at the end of the address-latch cycle. It holds that value unchanged while the word line, sense or recovery phases are active, so the array reads and writes the requested row.
- R6: `word_en_o` is high for WORD_CYC consecutive cycles per access.
- R7: On a read, `sense_en_o` is high for SENSE_CYC cycles that immediately follow the word-line phase, and `word_en_o` is low during them.
- R8: `rd_valid_o` pulses for one cycle, in the last sense cycle of a read, and never during a write.
- R9: On a write, `wr_drv_o` is high in exactly the word-line cycles, and `sense_en_o` stays low.
- R10: After the word-line phase (write) or the sense phase (read), a recovery of WREC_CYC or RREC_CYC cycles follows. During recovery, `busy_o` is high and word line, precharge, sense and write drivers are all low.
- R11: A request raised while `busy_o` is high is ignored. It starts no further access, and `row_addr_o` keeps the address of the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request, sampled while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Row address of the request |
| precharge_o | output | 1 | Bit-line precharge enable |
| addr_le_o | output | 1 | Row address latch enable |
| word_en_o | output | 1 | Word-line enable |
| sense_en_o | output | 1 | Sense-amplifier enable |
| wr_drv_o | output | 1 | Write-driver enable |
| rd_valid_o | output | 1 | Read data valid, one-cycle pulse |
| busy_o | output | 1 | Access in progress |
| row_addr_o | output | ADDR_W | Latched row address to the array |

## Verification
The assertions watch, on every cycle, the safety rules of the sequence: precharge and word line never overlap, a word-line rise always follows a cycle without precharge, the row address stays still while the array is open, the word line stays low right after it falls, write drivers only run together with the word line, and the read-valid pulse lasts a single cycle. Only the bench's scenarios can show the exact phase lengths and total access length for reads and writes, the data that actually reaches the right row, the spacing of back-to-back accesses, and that a request raised mid-access leaves no trace.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_PRE   = 3'd1,
    PH_LATCH = 3'd2,
    PH_WORD  = 3'd3,
    PH_SENSE = 3'd4,
    PH_RECOV = 3'd5
  } phase_t;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Number of cycles spent in a phase for the given access kind.
  function automatic int unsigned phase_len(
    input phase_t      ph,
    input logic        wr,
    input int unsigned pre_c,
    input int unsigned word_c,
    input int unsigned sense_c,
    input int unsigned rrec_c,
    input int unsigned wrec_c
  );
    case (ph)
      PH_PRE:   return pre_c;
      PH_LATCH: return 1;
      PH_WORD:  return word_c;
      PH_SENSE: return sense_c;
      PH_RECOV: return wr ? wrec_c : rrec_c;
      default:  return 1;
    endcase
  endfunction

  // Phase that follows a completed phase.
  function automatic phase_t phase_after(input phase_t ph, input logic wr);
    case (ph)
      PH_PRE:   return PH_LATCH;
      PH_LATCH: return PH_WORD;
      PH_WORD:  return wr ? PH_RECOV : PH_SENSE;
      PH_SENSE: return PH_RECOV;
      default:  return PH_IDLE;
    endcase
  endfunction

  // Total busy cycles of one access.
  function automatic int unsigned access_len(
    input logic        wr,
    input int unsigned pre_c,
    input int unsigned word_c,
    input int unsigned sense_c,
    input int unsigned rrec_c,
    input int unsigned wrec_c
  );
    return pre_c + 1 + word_c + (wr ? wrec_c : (sense_c + rrec_c));
  endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int unsigned PRE_CYC   = 1,
  parameter int unsigned WORD_CYC  = 2,
  parameter int unsigned SENSE_CYC = 1,
  parameter int unsigned RREC_CYC  = 1,
  parameter int unsigned WREC_CYC  = 2,
  parameter int unsigned CNT_W     = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  logic   req_write,
  output phase_t phase_o,
  output logic   wr_o,
  output logic   accept_o,
  output logic   last_o
);

  phase_t           phase_q, phase_d;
  logic             wr_q, wr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_end;

  assign at_end   = (cnt_q == '0);
  assign accept_o = (phase_q == PH_IDLE) && req_valid;

  always_comb begin
    phase_d = phase_q;
    wr_d    = wr_q;
    cnt_d   = cnt_q;
    if (phase_q == PH_IDLE) begin
      if (req_valid) begin
        phase_d = PH_PRE;
        wr_d    = req_write;
        cnt_d   = CNT_W'(phase_len(PH_PRE, req_write, PRE_CYC, WORD_CYC,
                                   SENSE_CYC, RREC_CYC, WREC_CYC) - 1);
      end
    end else if (at_end) begin
      phase_d = phase_after(phase_q, wr_q);
      cnt_d   = CNT_W'(phase_len(phase_d, wr_q, PRE_CYC, WORD_CYC,
                                 SENSE_CYC, RREC_CYC, WREC_CYC) - 1);
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      wr_q    <= 1'b0;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      wr_q    <= wr_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase_o = phase_q;
  assign wr_o    = wr_q;
  assign last_o  = at_end;

endmodule

// File: rtl/sram_seq_addr.sv
module sram_seq_addr #(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              latch_en,
  output logic [ADDR_W-1:0] row_addr_o
);

  logic [ADDR_W-1:0] pend_q;
  logic [ADDR_W-1:0] row_q;

  // Request address is captured only when an access is accepted.
  always_ff @(posedge clk) begin
    if (!rst_n)      pend_q <= '0;
    else if (accept) pend_q <= req_addr;
  end

  // The array-facing address moves only in the latch phase.
  always_ff @(posedge clk) begin
    if (!rst_n)        row_q <= '0;
    else if (latch_en) row_q <= pend_q;
  end

  assign row_addr_o = row_q;

endmodule

// File: rtl/sram_seq_decode.sv
module sram_seq_decode
  import sram_seq_pkg::*;
(
  input  phase_t phase,
  input  logic   wr,
  input  logic   last,
  output logic   pre_o,
  output logic   ale_o,
  output logic   word_o,
  output logic   sense_o,
  output logic   wdrv_o,
  output logic   rdv_o,
  output logic   busy_o,
  output logic   recov_o
);

  always_comb begin
    pre_o   = (phase == PH_PRE);
    ale_o   = (phase == PH_LATCH);
    word_o  = (phase == PH_WORD);
    sense_o = (phase == PH_SENSE);
    wdrv_o  = (phase == PH_WORD) && wr;
    rdv_o   = (phase == PH_SENSE) && last;
    busy_o  = (phase != PH_IDLE);
    recov_o = (phase == PH_RECOV);
  end

endmodule

// File: rtl/sram_seq_top.sv
module sram_seq_top
  import sram_seq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned PRE_CYC   = 1,
  parameter int unsigned WORD_CYC  = 2,
  parameter int unsigned SENSE_CYC = 1,
  parameter int unsigned RREC_CYC  = 1,
  parameter int unsigned WREC_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              precharge_o,
  output logic              addr_le_o,
  output logic              word_en_o,
  output logic              sense_en_o,
  output logic              wr_drv_o,
  output logic              rd_valid_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] row_addr_o
);

  localparam int unsigned MAX_LEN = max2(max2(max2(PRE_CYC, WORD_CYC),
                                              max2(SENSE_CYC, RREC_CYC)), WREC_CYC);
  localparam int unsigned CNT_W   = (MAX_LEN < 2) ? 1 : $clog2(MAX_LEN);

  phase_t phase_w;
  logic   wr_w, accept_w, last_w, recov_w;

  sram_seq_fsm #(
    .PRE_CYC  (PRE_CYC),
    .WORD_CYC (WORD_CYC),
    .SENSE_CYC(SENSE_CYC),
    .RREC_CYC (RREC_CYC),
    .WREC_CYC (WREC_CYC),
    .CNT_W    (CNT_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .phase_o  (phase_w),
    .wr_o     (wr_w),
    .accept_o (accept_w),
    .last_o   (last_w)
  );

  sram_seq_decode u_dec (
    .phase  (phase_w),
    .wr     (wr_w),
    .last   (last_w),
    .pre_o  (precharge_o),
    .ale_o  (addr_le_o),
    .word_o (word_en_o),
    .sense_o(sense_en_o),
    .wdrv_o (wr_drv_o),
    .rdv_o  (rd_valid_o),
    .busy_o (busy_o),
    .recov_o(recov_w)
  );

  sram_seq_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept_w),
    .req_addr  (req_addr),
    .latch_en  (addr_le_o),
    .row_addr_o(row_addr_o)
  );

  // R4
  pre_word_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(precharge_o && word_en_o));

  // R4
  pre_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_en_o) |-> !$past(precharge_o));

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_en_o || sense_en_o || recov_w) |=> $stable(row_addr_o));

  // R10
  recov_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(word_en_o) |-> !precharge_o && !wr_drv_o);

  // R10
  post_word_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(word_en_o) |=> !word_en_o);

  // R9
  wdrv_with_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drv_o |-> word_en_o && !sense_en_o);

  // R8
  rdv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |=> !rd_valid_o);

  // R3
  pre_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    precharge_o |-> busy_o);

endmodule

// File: tb/sim_sram_seq_top.sv
`timescale 1ns/1ps
module sim_sram_seq_top;

  localparam int AW  = 3;
  localparam int P   = 1;
  localparam int W   = 2;
  localparam int S   = 1;
  localparam int RR  = 1;
  localparam int WR  = 2;
  localparam int NW  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          precharge_o, addr_le_o, word_en_o, sense_en_o;
  logic          wr_drv_o, rd_valid_o, busy_o;
  logic [AW-1:0] row_addr_o;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;

  logic [7:0] mem    [NW];
  logic [7:0] shadow [NW];
  logic [7:0] wdata = 8'h00;

  always #2 clk = ~clk;

  sram_seq_top #(
    .ADDR_W(AW), .PRE_CYC(P), .WORD_CYC(W), .SENSE_CYC(S),
    .RREC_CYC(RR), .WREC_CYC(WR)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .precharge_o(precharge_o), .addr_le_o(addr_le_o),
    .word_en_o(word_en_o), .sense_en_o(sense_en_o), .wr_drv_o(wr_drv_o),
    .rd_valid_o(rd_valid_o), .busy_o(busy_o), .row_addr_o(row_addr_o)
  );

  // Behavioural array driven by the sequencer's controls.
  always @(posedge clk) begin
    if (word_en_o && wr_drv_o) mem[row_addr_o] <= wdata;
  end

  function automatic int acc_len(bit wr);
    if (wr) return P + 1 + W + WR;
    return P + 1 + W + S + RR;
  endfunction

  // {busy, rdv, wdrv, sense, word, ale, pre} expected i cycles after acceptance
  function automatic logic [6:0] expect_vec(int i, bit wr);
    int t;
    t = i;
    if (t < P) return 7'b1000001;
    t = t - P;
    if (t < 1) return 7'b1000010;
    t = t - 1;
    if (t < W) return wr ? 7'b1010100 : 7'b1000100;
    t = t - W;
    if (!wr) begin
      if (t < S) return (t == S - 1) ? 7'b1101000 : 7'b1001000;
      t = t - S;
      if (t < RR) return 7'b1000000;
    end else begin
      if (t < WR) return 7'b1000000;
    end
    return 7'b0000000;
  endfunction

  function automatic string tag_for(logic [6:0] d);
    if (d[0]) return "R3";
    if (d[1]) return "R4";
    if (d[2]) return "R6";
    if (d[3]) return "R7";
    if (d[5]) return "R8";
    if (d[4]) return "R9";
    return "R10";
  endfunction

  function automatic logic [6:0] actual_vec();
    return {busy_o, rd_valid_o, wr_drv_o, sense_en_o, word_en_o, addr_le_o, precharge_o};
  endfunction

  task automatic check_vec(int i, bit wr);
    logic [6:0] a, e;
    a = actual_vec();
    e = expect_vec(i, wr);
    vectors++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s cycle %0d wr=%0d: actual %b expected %b", tag_for(a ^ e), i, wr, a, e);
    end
  endtask

  // One access; inj raises a stray request while busy (R11).
  task automatic run_access(bit wr, logic [AW-1:0] addr, logic [7:0] data, bit inj);
    int len;
    len = acc_len(wr);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; wdata = data;
    @(posedge clk);
    for (int i = 0; i <= len + 1; i++) begin
      @(negedge clk);
      if (i == 0) req_valid = 1'b0;
      check_vec(i, wr);
      if (i >= P + 1 && i < len) begin
        vectors++;
        if (row_addr_o !== addr) begin
          fails++;
          $display("FAIL %s row address cycle %0d: actual %0d expected %0d",
                   inj ? "R11" : "R5", i, row_addr_o, addr);
        end
      end
      if (!wr && rd_valid_o) begin
        vectors++;
        if (mem[row_addr_o] !== shadow[addr]) begin
          fails++;
          $display("FAIL R5 read data addr %0d: actual %h expected %h",
                   addr, mem[row_addr_o], shadow[addr]);
        end
      end
      if (inj && i == 2) begin
        req_valid = 1'b1; req_write = ~wr; req_addr = ~addr;
      end
      if (inj && i == 3) req_valid = 1'b0;
    end
    if (wr) shadow[addr] = data;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL R2 watchdog: actual hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NW; k++) begin
      mem[k] = 8'h00;
      shadow[k] = 8'h00;
    end
    repeat (3) @(negedge clk);
    // R1: outputs low under reset
    vectors++;
    if (actual_vec() !== 7'b0) begin
      fails++;
      $display("FAIL R1 in reset: actual %b expected 0000000", actual_vec());
    end
    rst_n = 1'b1;
    @(negedge clk);
    // R1: still idle in the first cycle after reset
    vectors++;
    if (actual_vec() !== 7'b0) begin
      fails++;
      $display("FAIL R1 after reset: actual %b expected 0000000", actual_vec());
    end

    // Exhaustive writes then reads over all rows (R2..R10)
    for (int a = 0; a < NW; a++)
      run_access(1'b1, AW'(a), 8'(a * 37 + 5), 1'b0);
    for (int a = 0; a < NW; a++)
      run_access(1'b0, AW'(a), 8'h00, 1'b0);

    // Stray requests during busy are ignored (R11)
    for (int a = 0; a < NW; a++)
      run_access(a[0], AW'(a), 8'(a * 11 + 3), 1'b1);
    for (int a = 0; a < NW; a++)
      run_access(1'b0, AW'(a), 8'h00, 1'b1);

    // Back-to-back with request held: precharge rises every acc_len+1 cycles (R2)
    begin
      int last_rise, rises;
      logic prev_pre;
      last_rise = -1; rises = 0; prev_pre = 1'b0;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = 3'd5;
      for (int i = 0; i < 4 * (acc_len(1'b0) + 1); i++) begin
        @(negedge clk);
        if (precharge_o && !prev_pre) begin
          if (last_rise >= 0) begin
            vectors++;
            if (i - last_rise != acc_len(1'b0) + 1) begin
              fails++;
              $display("FAIL R2 access spacing: actual %0d expected %0d",
                       i - last_rise, acc_len(1'b0) + 1);
            end
          end
          last_rise = i;
          rises++;
        end
        prev_pre = precharge_o;
      end
      req_valid = 1'b0;
      vectors++;
      if (rises < 3) begin
        fails++;
        $display("FAIL R2 back-to-back starts: actual %0d expected >=3", rises);
      end
      repeat (acc_len(1'b1) + 2) @(negedge clk);
      vectors++;
      if (busy_o !== 1'b0) begin
        fails++;
        $display("FAIL R2 busy after drain: actual %b expected 0", busy_o);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule